// File: doc/BRIEF.md
# Symmetric Rounder with Positive Saturation

This block takes a signed fixed-point sample with integer and fractional bits and produces a signed integer word with the fraction removed. It sits at the end of a decimating filter chain. By default the input has 19 bits (16 integer, 3 fractional) and the output has 16 bits.

Rounding is to the nearest integer. A value exactly half-way between two integers moves away from zero. Positive and negative inputs are therefore treated as mirror images, so the rounding step adds no average offset and no 0 Hz tone to the data. The largest positive inputs can round up one step past the top of the output range. Those results are clamped to the largest positive code instead of wrapping round to the most negative code. Negative inputs can never leave the output range.

The input is qualified by a valid strobe. The result word and its valid strobe leave through registers, one clock after the input is accepted. The result register keeps its value through cycles in which no valid input arrives. A synchronous active-high reset clears both outputs.

Top module: `sym_round_sat`

## Requirements
- R1: For an input whose three fractional bits (`in_data[2:0]`) are not binary 100, `out_data` is the two's-complement integer nearest to `in_data / 8`.
- R2: A non-negative input with fraction bits 100 (exactly +x.5) rounds up to the next integer, away from zero.
- R3: A negative input with fraction bits 100 (exactly -x.5) rounds to the next more negative integer, away from zero.
- R4: A rounded result above +32767 is output as 0x7FFF and never wraps to a negative code.
- R5: The most negative inputs (down to 0x40000, which is -32768.0) give 0x8000 (-32768) without any clamping action.
- R6: `out_valid` equals the value `in_valid` had one clock earlier.
- R7: When `in_valid` is low, `out_data` keeps its previous value, whatever `in_data` carries.
- R8: A clock edge with `rst` high drives `out_valid` to 0 and `out_data` to 0 on the next cycle.
- R9: A non-negative accepted input (bit 18 clear) never produces an output with bit 15 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | High when `in_data` holds a sample to convert |
| in_data | input | 19 | Signed input sample, 3 fractional bits |
| out_valid | output | 1 | High for one cycle per converted sample |
| out_data | output | 16 | Signed rounded and saturated result |

## Verification
Two functions can act on the same sample: the round-away-from-zero increment and the positive clamp. Both apply when a positive input just below full scale has a half or larger fraction. For example, 0x3FFFC (+32767.5) becomes +32768 before clamping and must come out as 0x7FFF. The bench provokes these cases by driving the top eight input codes (0x3FFF8 to 0x3FFFF), by driving the mirror codes at the negative end, and by random samples. Each result is judged against an integer reference that rounds the magnitude and restores the sign, then clamps. That reference is compared with the output on every clock.

// File: rtl/sym_round_pkg.sv
package sym_round_pkg;

  // Which bias the rounding adder uses for the current sample.
  typedef enum logic {
    BIAS_NONNEG = 1'b0,
    BIAS_NEG    = 1'b1
  } bias_sel_e;

endpackage

// File: rtl/rnd_half_away.sv
module rnd_half_away
  import sym_round_pkg::*;
#(
  parameter int IN_W   = 19,
  parameter int FRAC_W = 3,
  localparam int OUT_W = IN_W - FRAC_W
) (
  input  logic [IN_W-1:0] din,
  output logic [OUT_W:0]  qwide
);

  localparam int EXT_W = IN_W + 1;
  localparam logic [EXT_W-1:0] HALF     = EXT_W'(1) << (FRAC_W - 1);
  localparam logic [EXT_W-1:0] HALF_M1  = HALF - EXT_W'(1);

  bias_sel_e        sel;
  logic [EXT_W-1:0] ext;
  logic [EXT_W-1:0] bias;
  logic [EXT_W-1:0] sum;

  always_comb begin
    sel = din[IN_W-1] ? BIAS_NEG : BIAS_NONNEG;
    ext = {din[IN_W-1], din};
    // Half-away-from-zero: +half for non-negative, (half-1) then floor for negative.
    bias = (sel == BIAS_NEG) ? HALF_M1 : HALF;
    sum  = ext + bias;
    qwide = sum[EXT_W-1:FRAC_W];
  end

endmodule

// File: rtl/rnd_clamp.sv
module rnd_clamp #(
  parameter int OUT_W = 16
) (
  input  logic [OUT_W:0]   qwide,
  output logic [OUT_W-1:0] qsat
);

  localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};

  logic pos_over;

  always_comb begin
    // Non-negative wide value whose narrow sign bit is set: positive overflow.
    pos_over = ~qwide[OUT_W] & qwide[OUT_W-1];
    qsat     = pos_over ? POS_MAX : qwide[OUT_W-1:0];
  end

endmodule

// File: rtl/rnd_out_stage.sv
module rnd_out_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic         vld_q,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      q     <= '0;
    end else begin
      vld_q <= load;
      if (load) q <= d;
    end
  end

endmodule

// File: rtl/sym_round_sat.sv
module sym_round_sat #(
  parameter int IN_W   = 19,
  parameter int FRAC_W = 3,
  localparam int OUT_W = IN_W - FRAC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);

  logic [OUT_W:0]   q_wide;
  logic [OUT_W-1:0] q_sat;

  rnd_half_away #(.IN_W(IN_W), .FRAC_W(FRAC_W)) u_round (
    .din   (in_data),
    .qwide (q_wide)
  );

  rnd_clamp #(.OUT_W(OUT_W)) u_clamp (
    .qwide (q_wide),
    .qsat  (q_sat)
  );

  rnd_out_stage #(.W(OUT_W)) u_out (
    .clk   (clk),
    .rst   (rst),
    .load  (in_valid),
    .d     (q_sat),
    .vld_q (out_valid),
    .q     (out_data)
  );

endmodule

// File: rtl/sym_round_sat_chk.sv
module sym_round_sat_chk #(
  parameter int IN_W  = 19,
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [IN_W-1:0]  in_data,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data
);

  // R6: valid strobe delayed by exactly one clock
  a_r6_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r6_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R7: result held while no sample is accepted
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));

  // R8: reset clears the outputs
  a_r8_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

  // R9 / R4: non-negative input never gives a negative result
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_data[IN_W-1]) |=> !out_data[OUT_W-1]);

  // R3 / R5: negative input gives negative or zero result
  a_r5_neg_sign: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_data[IN_W-1]) |=> (out_data[OUT_W-1] || out_data == '0));

endmodule

bind sym_round_sat sym_round_sat_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/sym_round_sat_test.sv
`timescale 1ns/1ps
module sym_round_sat_test;

  localparam int IN_W  = 19;
  localparam int FRAC_W = 3;
  localparam int OUT_W = IN_W - FRAC_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [IN_W-1:0]  in_data = '0;
  logic             out_valid;
  logic [OUT_W-1:0] out_data;

  int errors = 0;
  int checks = 0;
  int exp_data = 0;
  bit exp_valid = 1'b0;

  always #4 clk = ~clk;

  sym_round_sat uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic int to_int_in(input logic [IN_W-1:0] d);
    int x = int'(d);
    if (d[IN_W-1]) x = x - (1 << IN_W);
    return x;
  endfunction

  function automatic int to_int_out(input logic [OUT_W-1:0] d);
    int x = int'(d);
    if (d[OUT_W-1]) x = x - (1 << OUT_W);
    return x;
  endfunction

  // Unclamped reference: round magnitude half up, restore sign.
  function automatic int ref_raw(input int x);
    if (x >= 0) return (x + 4) / 8;
    return -((-x + 4) / 8);
  endfunction

  function automatic int ref_sat(input int x);
    int q = ref_raw(x);
    if (q > 32767) q = 32767;
    return q;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at a falling edge: drive, wait for the rising edge, update model,
  // then compare at the next falling edge.
  task automatic step(input bit r, input bit v, input logic [IN_W-1:0] d);
    int x;
    string tag;
    rst = r; in_valid = v; in_data = d;
    x = to_int_in(d);
    @(posedge clk);
    if (r) begin
      exp_valid = 1'b0; exp_data = 0; tag = "R8";
    end else begin
      exp_valid = v;
      if (v) begin
        exp_data = ref_sat(x);
        if (ref_raw(x) > 32767)       tag = "R4";
        else if (exp_data == -32768)  tag = "R5";
        else if (d[2:0] == 3'b100)    tag = (x >= 0) ? "R2" : "R3";
        else                          tag = "R1";
      end else begin
        tag = "R7";
      end
    end
    @(negedge clk);
    check(r ? "R8" : "R6", int'(out_valid), int'(exp_valid));
    check(tag, to_int_out(out_data), exp_data);
    if (!r && v && x >= 0) check("R9", int'(out_data[OUT_W-1]), 0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(1, 0, '0);
    step(1, 1, 19'h3FFFF);                 // R8 reset dominates valid
    // R1 nearest, R2/R3 half cases
    step(0, 1, 19'd0);
    step(0, 1, 19'd3);
    step(0, 1, 19'd4);                     // +0.5 -> 1 (R2)
    step(0, 1, 19'd5);
    step(0, 1, 19'd12);                    // +1.5 -> 2 (R2)
    step(0, 1, -19'sd3);
    step(0, 1, -19'sd4);                   // -0.5 -> -1 (R3)
    step(0, 1, -19'sd5);
    step(0, 1, -19'sd12);                  // -1.5 -> -2 (R3)
    // R7: garbage on in_data while idle
    step(0, 0, 19'h3FFFF);
    step(0, 0, 19'h40000);
    // R4: top codes, rounding and clamp in the same sample
    for (int k = 8; k >= 0; k--) step(0, 1, 19'h3FFFF - 19'(k));
    // R5: bottom codes
    for (int k = 0; k < 9; k++) step(0, 1, 19'h40000 + 19'(k));
    // R6: alternating valid
    for (int k = 0; k < 6; k++) step(0, k[0], 19'(k * 37));
    // Random traffic with a mid-run reset
    for (int k = 0; k < 3000; k++) begin
      logic [IN_W-1:0] d = IN_W'($urandom);
      step(k == 1500, ($urandom % 4) != 0, d);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule